// File: doc/BRIEF.md
# MSI Write Decoder with Requester PE Check

This block sits on the inbound path of a PCI Express root complex and turns message-signalled interrupt writes into source triggers. Each write carries a 64-bit address, a 16-bit data word and, optionally, the partitionable-endpoint (PE) number of the requester. The decoder builds a 16-bit source number from the address and data, discards sources beyond the configured count, and, when a requester PE is given, reads the owning PE of that source from an external vector table. It issues a one-cycle trigger only when the source number is in range and the PE check passes. Dropped writes raise a one-cycle error flag with a reason code.

A second entry point serves a forced-interrupt register. A write to it is decoded like an MSI whose address is the written value and whose data is zero. It skips the PE check. When the decoder accepts it, a software lock bit is released. The vector table is external: the block issues a single read strobe with an index and waits for a response of any latency. Only one write is in flight at a time.

Top module: `msi_write_decoder`

## Requirements
- R1: The source number is address bits [19:4] OR-ed with data bits [4:0] zero-extended to 16 bits.
- R2: A source number not below the effective source count is dropped: no trigger, and `err_valid` pulses for one cycle with `err_code` = 2'b01 (bounds).
- R3: The effective source count is `cfg_count` clamped to `MAX_SRC` (default 2048).
- R4: A write accepted with `req_pe_valid` set and an in-range source raises `tbl_rd_en` for exactly one cycle, in the cycle after acceptance, with `tbl_rd_idx` equal to the source. If the PE returned on `tbl_rsp_valid` equals the requester PE, the trigger fires in the cycle after the response and not before.
- R5: If the returned PE differs from the requester PE, the write is dropped, and `err_valid` pulses with `err_code` = 2'b10 (PE mismatch).
- R6: A write accepted with `req_pe_valid` low and an in-range source triggers in the cycle after acceptance, with no table read.
- R7: `trig_valid` is a one-cycle pulse per accepted write. `trig_src` is the source, and `trig_irq` is `cfg_base` plus the source, using the `cfg_base` value present at the edge that emits the trigger.
- R8: While a table lookup is outstanding, `req_ready` and `ffi_ready` are low. Writes offered in that time are neither accepted nor triggered.
- R9: An accepted forced-interrupt write uses `ffi_value` as the address and zero as the data. It applies the bounds check, performs no table read, and triggers or errors in the next cycle.
- R10: `ffi_lock` is set by `ffi_lock_set` and cleared by the edge that accepts a forced-interrupt write. Clearing wins when both happen in the same cycle.
- R11: After reset, `trig_valid`, `err_valid`, `tbl_rd_en` and `ffi_lock` are 0, and both ready outputs are 1.
- R12: When a forced-interrupt write and an MSI write are offered together while idle, the forced write is accepted and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_count | input | 17 | Configured number of sources (clamped) |
| cfg_base | input | IRQ_W | Offset added to the source for the global interrupt number |
| req_valid | input | 1 | MSI write offered |
| req_ready | output | 1 | MSI write accepted when valid is also high |
| req_addr | input | 64 | MSI write address |
| req_data | input | 16 | MSI write data |
| req_pe_valid | input | 1 | Requester PE number is supplied |
| req_pe | input | PE_W | Requester PE number |
| ffi_valid | input | 1 | Forced-interrupt register write offered |
| ffi_ready | output | 1 | Forced-interrupt write accepted when valid is also high |
| ffi_value | input | 64 | Value written to the forced-interrupt register |
| ffi_lock_set | input | 1 | Software sets the forced-interrupt lock |
| ffi_lock | output | 1 | Forced-interrupt lock state |
| tbl_rd_en | output | 1 | Vector table read strobe |
| tbl_rd_idx | output | 16 | Vector table entry index |
| tbl_rsp_valid | input | 1 | Table read response valid |
| tbl_rsp_pe | input | PE_W | PE field of the entry read |
| trig_valid | output | 1 | One-cycle source trigger |
| trig_src | output | 16 | Triggered source number |
| trig_irq | output | IRQ_W | Base plus source |
| err_valid | output | 1 | One-cycle drop indication |
| err_code | output | 2 | Drop reason: 01 bounds, 10 PE mismatch |

## Verification
The hardest case is a write that arrives while a PE lookup is outstanding. To create it, the table must respond late and a second writer must be pushing at the same time. The bench holds the table response back for one to three cycles. During that wait it drives both an MSI write and a forced write with in-range sources, and it changes `cfg_base`. It then checks that the readies stay low, that only the original source triggers, and that the trigger carries the base value present at the response. Random traffic with a fixed seed mixes source counts above and below the clamp, matching and mismatching PEs, and forced writes.

// File: rtl/msi_dec_pkg.sv
package msi_dec_pkg;
    localparam int SRC_W      = 16;          // width of a source number
    localparam int CNT_W      = SRC_W + 1;   // a count may reach 2**SRC_W
    localparam int DATA_BITS  = 5;           // data bits merged into the source
    localparam int ADDR_SHIFT = 4;           // address bits dropped below the source

    typedef enum logic [1:0] {
        ERR_NONE   = 2'b00,
        ERR_BOUNDS = 2'b01,
        ERR_PEMIS  = 2'b10
    } err_code_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_LOOKUP = 1'b1
    } dec_state_e;
endpackage

// File: rtl/msi_src_decode.sv
module msi_src_decode
    import msi_dec_pkg::*;
#(
    parameter int MAX_SRC = 2048
) (
    input  logic [63:0]      addr,
    input  logic [15:0]      data,
    input  logic [CNT_W-1:0] cfg_count,
    output logic [SRC_W-1:0] src,
    output logic             in_range
);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_SRC);

    logic [CNT_W-1:0] eff_count;

    always_comb begin
        src       = addr[ADDR_SHIFT +: SRC_W] | SRC_W'(data[DATA_BITS-1:0]);
        eff_count = (cfg_count > MAX_C) ? MAX_C : cfg_count;
        in_range  = {1'b0, src} < eff_count;
    end
endmodule

// File: rtl/msi_ffi_lock.sv
module msi_ffi_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic lock_o
);
    logic lock_d, lock_q;

    always_comb begin
        lock_d = lock_q;
        if (set_i) lock_d = 1'b1;
        if (clr_i) lock_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= 1'b0;
        else        lock_q <= lock_d;
    end

    assign lock_o = lock_q;
endmodule

// File: rtl/msi_write_decoder.sv
module msi_write_decoder
    import msi_dec_pkg::*;
#(
    parameter int PE_W    = 8,
    parameter int IRQ_W   = 20,
    parameter int MAX_SRC = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic [IRQ_W-1:0] cfg_base,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [63:0]      req_addr,
    input  logic [15:0]      req_data,
    input  logic             req_pe_valid,
    input  logic [PE_W-1:0]  req_pe,
    input  logic             ffi_valid,
    output logic             ffi_ready,
    input  logic [63:0]      ffi_value,
    input  logic             ffi_lock_set,
    output logic             ffi_lock,
    output logic             tbl_rd_en,
    output logic [SRC_W-1:0] tbl_rd_idx,
    input  logic             tbl_rsp_valid,
    input  logic [PE_W-1:0]  tbl_rsp_pe,
    output logic             trig_valid,
    output logic [SRC_W-1:0] trig_src,
    output logic [IRQ_W-1:0] trig_irq,
    output logic             err_valid,
    output logic [1:0]       err_code
);
    localparam int NUM_PORTS = 2;    // 0: MSI write, 1: forced write
    localparam int P_REQ     = 0;
    localparam int P_FFI     = 1;

    typedef struct packed {
        dec_state_e       st;
        logic             rd_en;
        logic [SRC_W-1:0] src;
        logic [PE_W-1:0]  pe;
        logic             trig;
        logic [IRQ_W-1:0] irq;
        logic             err;
        err_code_e        code;
    } dec_regs_t;

    dec_regs_t r_d, r_q;

    logic [63:0]      p_addr     [NUM_PORTS];
    logic [15:0]      p_data     [NUM_PORTS];
    logic [SRC_W-1:0] p_src      [NUM_PORTS];
    logic             p_in_range [NUM_PORTS];

    assign p_addr[P_REQ] = req_addr;
    assign p_data[P_REQ] = req_data;
    assign p_addr[P_FFI] = ffi_value;
    assign p_data[P_FFI] = 16'h0000;

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_dec
        msi_src_decode #(.MAX_SRC(MAX_SRC)) u_dec (
            .addr      (p_addr[g]),
            .data      (p_data[g]),
            .cfg_count (cfg_count),
            .src       (p_src[g]),
            .in_range  (p_in_range[g])
        );
    end

    logic ffi_acc, req_acc;

    always_comb begin
        ffi_ready = (r_q.st == ST_IDLE);
        req_ready = (r_q.st == ST_IDLE) && !ffi_valid;
        ffi_acc   = ffi_valid && ffi_ready;
        req_acc   = req_valid && req_ready;

        r_d       = r_q;
        r_d.rd_en = 1'b0;
        r_d.trig  = 1'b0;
        r_d.err   = 1'b0;
        r_d.code  = ERR_NONE;

        if (ffi_acc) begin
            r_d.src = p_src[P_FFI];
            if (p_in_range[P_FFI]) begin
                r_d.trig = 1'b1;
                r_d.irq  = cfg_base + IRQ_W'(p_src[P_FFI]);
            end else begin
                r_d.err  = 1'b1;
                r_d.code = ERR_BOUNDS;
            end
        end else if (req_acc) begin
            r_d.src = p_src[P_REQ];
            if (!p_in_range[P_REQ]) begin
                r_d.err  = 1'b1;
                r_d.code = ERR_BOUNDS;
            end else if (req_pe_valid) begin
                r_d.st    = ST_LOOKUP;
                r_d.rd_en = 1'b1;
                r_d.pe    = req_pe;
            end else begin
                r_d.trig = 1'b1;
                r_d.irq  = cfg_base + IRQ_W'(p_src[P_REQ]);
            end
        end else if (r_q.st == ST_LOOKUP && tbl_rsp_valid) begin
            r_d.st = ST_IDLE;
            if (tbl_rsp_pe == r_q.pe) begin
                r_d.trig = 1'b1;
                r_d.irq  = cfg_base + IRQ_W'(r_q.src);
            end else begin
                r_d.err  = 1'b1;
                r_d.code = ERR_PEMIS;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, code: ERR_NONE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    msi_ffi_lock u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ffi_lock_set),
        .clr_i  (ffi_acc),
        .lock_o (ffi_lock)
    );

    assign tbl_rd_en  = r_q.rd_en;
    assign tbl_rd_idx = r_q.src;
    assign trig_valid = r_q.trig;
    assign trig_src   = r_q.src;
    assign trig_irq   = r_q.irq;
    assign err_valid  = r_q.err;
    assign err_code   = r_q.code;
endmodule

// File: rtl/msi_write_decoder_chk.sv
module msi_write_decoder_chk
    import msi_dec_pkg::*;
#(
    parameter int MAX_SRC = 2048
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_pe_valid,
    input logic             ffi_valid,
    input logic             ffi_ready,
    input logic             ffi_lock,
    input logic             tbl_rd_en,
    input logic             trig_valid,
    input logic [SRC_W-1:0] trig_src,
    input logic             err_valid,
    input logic [1:0]       err_code
);
    assert_trig_err_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(trig_valid && err_valid));

    assert_err_code_known_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (err_code == 2'b01 || err_code == 2'b10));

    assert_src_below_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid |-> ({1'b0, trig_src} < CNT_W'(MAX_SRC)));

    assert_rd_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd_en |=> !tbl_rd_en);

    assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd_en |-> (!req_ready && !ffi_ready));

    assert_no_pe_no_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_pe_valid) |=> !tbl_rd_en);

    assert_ffi_no_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ffi_valid && ffi_ready) |=> !tbl_rd_en);

    assert_ffi_unlock_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ffi_valid && ffi_ready) |=> !ffi_lock);

    assert_ffi_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ffi_valid |-> !req_ready);
endmodule

bind msi_write_decoder msi_write_decoder_chk #(.MAX_SRC(MAX_SRC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_pe_valid (req_pe_valid),
    .ffi_valid    (ffi_valid),
    .ffi_ready    (ffi_ready),
    .ffi_lock     (ffi_lock),
    .tbl_rd_en    (tbl_rd_en),
    .trig_valid   (trig_valid),
    .trig_src     (trig_src),
    .err_valid    (err_valid),
    .err_code     (err_code)
);

// File: tb/sim_msi_write_decoder.sv
module sim_msi_write_decoder;
    localparam int PE_W  = 8;
    localparam int IRQ_W = 20;
    localparam int MAXS  = 2048;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [16:0] cfg_count = 17'd100;
    logic [IRQ_W-1:0] cfg_base = '0;
    logic req_valid = 0, req_ready, req_pe_valid = 0;
    logic [63:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic [PE_W-1:0] req_pe = '0;
    logic ffi_valid = 0, ffi_ready, ffi_lock_set = 0, ffi_lock;
    logic [63:0] ffi_value = '0;
    logic tbl_rd_en, tbl_rsp_valid = 0;
    logic [15:0] tbl_rd_idx;
    logic [PE_W-1:0] tbl_rsp_pe = '0;
    logic trig_valid, err_valid;
    logic [15:0] trig_src;
    logic [IRQ_W-1:0] trig_irq;
    logic [1:0] err_code;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    msi_write_decoder #(.PE_W(PE_W), .IRQ_W(IRQ_W), .MAX_SRC(MAXS)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_count(cfg_count), .cfg_base(cfg_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_data(req_data), .req_pe_valid(req_pe_valid), .req_pe(req_pe),
        .ffi_valid(ffi_valid), .ffi_ready(ffi_ready), .ffi_value(ffi_value),
        .ffi_lock_set(ffi_lock_set), .ffi_lock(ffi_lock),
        .tbl_rd_en(tbl_rd_en), .tbl_rd_idx(tbl_rd_idx),
        .tbl_rsp_valid(tbl_rsp_valid), .tbl_rsp_pe(tbl_rsp_pe),
        .trig_valid(trig_valid), .trig_src(trig_src), .trig_irq(trig_irq),
        .err_valid(err_valid), .err_code(err_code)
    );

    function automatic logic [15:0] f_src(logic [63:0] a, logic [15:0] d);
        return a[19:4] | {11'd0, d[4:0]};
    endfunction

    function automatic logic [16:0] f_lim(logic [16:0] c);
        return (c > 17'(MAXS)) ? 17'(MAXS) : c;
    endfunction

    function automatic logic [PE_W-1:0] f_tpe(logic [15:0] i);
        return i[7:0] ^ 8'h5A;
    endfunction

    task automatic chk(input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // MSI write; lat = cycles the table holds its answer back; stray = push other writers meanwhile
    task automatic do_req(input logic [63:0] a, input logic [15:0] d, input logic pev,
                          input logic [PE_W-1:0] pe, input int lat, input bit stray,
                          input logic [IRQ_W-1:0] late_base);
        logic [15:0] s;
        logic inr;
        logic [15:0] idx;
        s   = f_src(a, d);
        inr = {1'b0, s} < f_lim(cfg_count);
        @(negedge clk);
        chk("R8", "idle ready", req_ready, 1'b1);
        req_valid = 1; req_addr = a; req_data = d; req_pe_valid = pev; req_pe = pe;
        @(posedge clk); #1;
        req_valid = 0; req_pe_valid = 0;
        @(negedge clk);
        if (!inr) begin
            chk("R2", "err_valid", err_valid, 1'b1);
            chk("R2", "err_code", err_code, 2'b01);
            chk("R2", "trig_valid", trig_valid, 1'b0);
            chk("R2", "tbl_rd_en", tbl_rd_en, 1'b0);
        end else if (pev) begin
            chk("R4", "tbl_rd_en", tbl_rd_en, 1'b1);
            chk("R1", "tbl_rd_idx", tbl_rd_idx, s);
            chk("R4", "early trig", trig_valid, 1'b0);
            idx = tbl_rd_idx;
            for (int k = 0; k < lat; k++) begin
                if (stray) begin
                    req_valid = 1; req_addr = 64'h0; req_data = 16'h0;
                    ffi_valid = 1; ffi_value = 64'h10;
                    cfg_base = late_base;
                    #1;
                    chk("R8", "req_ready busy", req_ready, 1'b0);
                    chk("R8", "ffi_ready busy", ffi_ready, 1'b0);
                end
                @(negedge clk);
                chk("R4", "trig while waiting", trig_valid, 1'b0);
                chk("R4", "single read", tbl_rd_en, 1'b0);
            end
            req_valid = 0; ffi_valid = 0;
            tbl_rsp_valid = 1; tbl_rsp_pe = f_tpe(idx);
            @(posedge clk); #1;
            tbl_rsp_valid = 0;
            @(negedge clk);
            if (pe == f_tpe(s)) begin
                chk("R4", "trig after match", trig_valid, 1'b1);
                chk("R8", "trig_src", trig_src, s);
                chk("R7", "trig_irq", trig_irq, IRQ_W'(cfg_base + IRQ_W'(s)));
                chk("R4", "no err", err_valid, 1'b0);
            end else begin
                chk("R5", "err_valid", err_valid, 1'b1);
                chk("R5", "err_code", err_code, 2'b10);
                chk("R5", "trig_valid", trig_valid, 1'b0);
            end
        end else begin
            chk("R6", "trig_valid", trig_valid, 1'b1);
            chk("R1", "trig_src", trig_src, s);
            chk("R7", "trig_irq", trig_irq, IRQ_W'(cfg_base + IRQ_W'(s)));
            chk("R6", "tbl_rd_en", tbl_rd_en, 1'b0);
            chk("R6", "err_valid", err_valid, 1'b0);
        end
        @(negedge clk);
        chk("R7", "trig pulse ends", trig_valid, 1'b0);
        chk("R7", "err pulse ends", err_valid, 1'b0);
    endtask

    task automatic do_ffi(input logic [63:0] v, input bit with_req, input bit lockset);
        logic [15:0] s;
        logic inr;
        s   = v[19:4];
        inr = {1'b0, s} < f_lim(cfg_count);
        @(negedge clk);
        ffi_valid = 1; ffi_value = v; ffi_lock_set = lockset;
        if (with_req) begin
            req_valid = 1; req_addr = 64'h20; req_data = 16'h0; req_pe_valid = 0;
        end
        #1;
        chk("R12", "req_ready with ffi", req_ready, 1'b0);
        @(posedge clk); #1;
        ffi_valid = 0; ffi_lock_set = 0; req_valid = 0;
        @(negedge clk);
        if (inr) begin
            chk("R9", "trig_valid", trig_valid, 1'b1);
            chk("R9", "trig_src", trig_src, s);
            chk("R9", "trig_irq", trig_irq, IRQ_W'(cfg_base + IRQ_W'(s)));
        end else begin
            chk("R9", "err bounds", err_valid, 1'b1);
            chk("R9", "err_code", err_code, 2'b01);
        end
        chk("R9", "no table read", tbl_rd_en, 1'b0);
        chk("R10", "lock cleared", ffi_lock, 1'b0);
        @(negedge clk);
        chk("R12", "req not taken", trig_valid, 1'b0);
    endtask

    task automatic set_lock();
        @(negedge clk);
        ffi_lock_set = 1;
        @(posedge clk); #1;
        ffi_lock_set = 0;
        @(negedge clk);
        chk("R10", "lock set", ffi_lock, 1'b1);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R11", "trig_valid", trig_valid, 1'b0);
        chk("R11", "err_valid", err_valid, 1'b0);
        chk("R11", "tbl_rd_en", tbl_rd_en, 1'b0);
        chk("R11", "ffi_lock", ffi_lock, 1'b0);
        chk("R11", "req_ready", req_ready, 1'b1);
        chk("R11", "ffi_ready", ffi_ready, 1'b1);

        // directed corners
        cfg_count = 17'd100; cfg_base = 20'h00400;
        do_req(64'h0000_0000_0000_0350, 16'h000C, 0, 0, 0, 0, 0);   // R1: 0x35|0x0C = 0x3D
        do_req(64'h0000_0000_0000_0640, 16'h0000, 0, 0, 0, 0, 0);   // R2: 100 == count
        do_req(64'h0000_0000_0000_0630, 16'h0003, 0, 0, 0, 0, 0);   // 99 in range
        do_req(64'h0000_0000_0000_0200, 16'h0000, 1, f_tpe(16'h20), 2, 1, 20'h12345); // R8, R7
        do_req(64'h0000_0000_0000_0200, 16'h0000, 1, 8'h00, 1, 0, 0); // R5 mismatch
        cfg_count = 17'h1FFFF;                                       // R3 clamp
        do_req(64'h0000_0000_0000_7FF0, 16'h0000, 0, 0, 0, 0, 0);   // 2047 ok
        do_req(64'h0000_0000_0000_8000, 16'h0000, 0, 0, 0, 0, 0);   // 2048 dropped
        set_lock();
        do_ffi(64'hFFFF_0000_0000_0150, 1, 0);                      // R9, R12
        do_ffi(64'h0000_0000_000F_0000, 0, 1);                      // R10 clear wins, R9 bounds
        set_lock();
        do_ffi(64'h0000_0000_0000_0010, 0, 0);

        // constrained random traffic
        for (int it = 0; it < 300; it++) begin
            logic [15:0] s;
            logic [63:0] a;
            logic [15:0] d;
            logic [PE_W-1:0] pe;
            int sel;
            sel = int'($urandom_range(0, 3));
            cfg_count = (sel == 0) ? 17'($urandom_range(0, 65536)) : 17'($urandom_range(1, 3000));
            cfg_base  = IRQ_W'($urandom);
            s = 16'($urandom_range(0, 3200));
            a = {$urandom, 12'($urandom), s, 4'($urandom)};
            d = 16'($urandom);
            if ($urandom_range(0, 4) == 0) begin
                if ($urandom_range(0, 1) == 1) set_lock();
                do_ffi(a, bit'($urandom_range(0, 1)), 0);
            end else begin
                pe = ($urandom_range(0, 9) < 7) ? f_tpe(f_src(a, d)) : PE_W'($urandom);
                do_req(a, d, logic'($urandom_range(0, 1)), pe,
                       int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)),
                       IRQ_W'($urandom));
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule